// File: doc/BRIEF.md
# SMBus Clock-Configuration Register Slave

This block is the serial control port of a clock generator. It holds a small bank of 8-bit configuration registers. A system controller reads and writes them over SMBus with four transfer types: byte write, byte read, block write and block read. SCL and SDA arrive as plain inputs and pass through internal synchronizers. The block drives the bus only through an open-drain pull-down request.

Bit 7 of the command byte picks the access type. When it is 1, the access is a single indexed byte at offset bits 6:0. When it is 0, the access is a block that always starts at offset 0 and carries a byte count. The writable registers appear as one parallel output word. Two read-only registers show the latched frequency-select straps and an identification byte. A frequency code output takes either the straps or a register copy, chosen by an override bit.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1101001, sent as D2h for a write and D3h for a read. Any other address gets no ACK, and no register changes.
- R2: In a byte write, the command has bit 7 = 1 and the offset in bits 6:0. The one data byte that follows is stored at that offset, and the command and data bytes are each acknowledged.
- R3: In a byte read, the command is written, then a repeated START and a read address follow. The slave returns the byte at the offset, MSB first, and the master ends with NACK and STOP.
- R4: In a block write, the command is 00h, followed by a count byte and then data bytes. The data go to offsets 0, 1, 2 and upward. Data bytes beyond the count are acknowledged and discarded. A STOP after any complete byte keeps the bytes already written.
- R5: In a block read, the command is 00h, followed by a repeated START and a read address. The slave returns a count of 6 (the number of readable registers), then offsets 0 upward. Past offset 5 it returns 00h.
- R6: After reset, the writable registers at offsets 0 to 3 hold 82h, 0Bh, FFh and 5Ah. The slave does not pull SDA.
- R7: Offset 4 reads {0000, strap_i}. Offset 5 reads the identification byte, with a high nibble of 1000 and a revision nibble of 3 (83h). Writes to both are acknowledged and have no effect.
- R8: Offset 0 bit 3 is the override bit. When it is 0, freq_sel_o follows strap_i. When it is 1, freq_sel_o equals offset 0 bits 7:4.
- R9: Writes to offsets 6 and above are acknowledged and discarded. Reads of those offsets return 00h.
- R10: The slave changes its SDA pull request only while the synchronized SCL is low. A STOP releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset to defaults |
| scl_i | input | 1 | SMBus clock level |
| sda_i | input | 1 | SMBus data level (wired bus value) |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_i | input | 4 | Latched frequency-select straps |
| cfg_o | output | 32 | Writable registers, offset n at bits 8n+7:8n |
| freq_sel_o | output | 4 | Selected frequency code |

## Verification
Single-byte accesses go to writable, read-only and out-of-range offsets. These show whether the offset decode, the read-only protection and the 00h fill are handled separately. Block writes run with surplus data, with an early STOP, and with a foreign address. These show the count limit apart from the truncation and apart from address filtering. A full block read, run past the last register, checks the count byte and the ordering. Override toggling together with strap changes shows which source drives the frequency code.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} link_st_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} rx_kind_e;
  localparam int PTR_W = 7;
endpackage

// File: rtl/smb_sync_edge.sv
module smb_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_o;
      sda_d  <= sda_o;
    end
  end

  assign scl_o   = scl_sh[SYNC_STAGES-1];
  assign sda_o   = sda_sh[SYNC_STAGES-1];
  // data edges while clock stays high
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter int              N_RW        = 4,
  parameter logic [N_RW*8-1:0] RW_DEFAULTS = 32'h5AFF0B82,
  parameter logic [3:0]      REV_ID      = 4'h3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  input  logic [3:0]       strap_i,
  output logic [7:0]       rd_data_o,
  output logic [N_RW*8-1:0] cfg_o
);
  localparam int STRAP_OFS = N_RW;
  localparam int ID_OFS    = N_RW + 1;

  logic [7:0] regs_q [N_RW];

  for (genvar g = 0; g < N_RW; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     regs_q[g] <= RW_DEFAULTS[g*8 +: 8];
      else if (wr_en_i && wr_addr_i == PTR_W'(g))      regs_q[g] <= wr_data_i;
    end
    assign cfg_o[g*8 +: 8] = regs_q[g];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < N_RW; i++)
      if (rd_addr_i == PTR_W'(i)) rd_data_o = regs_q[i];
    if (rd_addr_i == PTR_W'(STRAP_OFS)) rd_data_o = {4'h0, strap_i};
    if (rd_addr_i == PTR_W'(ID_OFS))    rd_data_o = {4'b1000, REV_ID};
  end
endmodule

// File: rtl/smb_link.sv
module smb_link
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         N_RD     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [7:0]       rd_data_i,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_pull_o
);
  link_st_e   st;
  rx_kind_e   kind;
  logic [2:0] bitcnt;
  logic [7:0] shreg, wcnt;
  logic [PTR_W-1:0] ptr;
  logic       blk, cnt_pend, rd_go, got;
  logic [7:0] tx_byte;

  assign tx_byte   = cnt_pend ? 8'(N_RD) : rd_data_i;
  assign rd_addr_o = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; kind <= K_ADDR; bitcnt <= '0; shreg <= '0; wcnt <= '0;
      ptr <= '0; blk <= 1'b0; cnt_pend <= 1'b0; rd_go <= 1'b0; got <= 1'b0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0; sda_pull_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st <= ST_RX; kind <= K_ADDR; bitcnt <= '0; got <= 1'b0; sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        st <= ST_IDLE; got <= 1'b0; sda_pull_o <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (rise_i) begin
              shreg  <= {shreg[6:0], sda_s_i};
              bitcnt <= bitcnt + 3'd1;
              got    <= (bitcnt == 3'd7);
            end else if (fall_i && got) begin
              got <= 1'b0;
              sda_pull_o <= 1'b1;
              st <= ST_RX_ACK;
              unique case (kind)
                K_ADDR: begin
                  if (shreg[7:1] == SLV_ADDR) begin
                    rd_go <= shreg[0];
                    kind  <= K_CMD;
                  end else begin
                    sda_pull_o <= 1'b0;
                    st <= ST_IDLE;
                  end
                end
                K_CMD: begin
                  blk      <= ~shreg[7];
                  cnt_pend <= ~shreg[7];
                  ptr      <= shreg[7] ? shreg[6:0] : '0;
                  kind     <= shreg[7] ? K_DATA : K_CNT;
                end
                K_CNT: begin
                  wcnt <= shreg; cnt_pend <= 1'b0; kind <= K_DATA;
                end
                default: begin
                  if (!blk || wcnt != 8'd0) begin
                    wr_en_o <= 1'b1; wr_addr_o <= ptr; wr_data_o <= shreg;
                  end
                  if (blk && wcnt != 8'd0) wcnt <= wcnt - 8'd1;
                  ptr <= ptr + 7'd1;
                end
              endcase
            end
          end
          ST_RX_ACK: if (fall_i) begin
            bitcnt <= '0;
            if (rd_go) begin
              st <= ST_TX; shreg <= tx_byte; sda_pull_o <= ~tx_byte[7];
              if (cnt_pend) cnt_pend <= 1'b0; else ptr <= ptr + 7'd1;
            end else begin
              st <= ST_RX; sda_pull_o <= 1'b0;
            end
          end
          ST_TX: if (fall_i) begin
            if (bitcnt == 3'd7) begin
              sda_pull_o <= 1'b0; st <= ST_TX_ACK;
            end else begin
              bitcnt <= bitcnt + 3'd1;
              shreg  <= {shreg[6:0], 1'b0};
              sda_pull_o <= ~shreg[6];
            end
          end
          ST_TX_ACK: begin
            if (rise_i) begin
              if (sda_s_i) st <= ST_IDLE;
              else got <= 1'b1;
            end else if (fall_i && got) begin
              got <= 1'b0; bitcnt <= '0; st <= ST_TX;
              shreg <= tx_byte; sda_pull_o <= ~tx_byte[7];
              if (cnt_pend) cnt_pend <= 1'b0; else ptr <= ptr + 7'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
  import clkcfg_pkg::*;
#(
  parameter int                N_RW        = 4,
  parameter logic [N_RW*8-1:0] RW_DEFAULTS = 32'h5AFF0B82,
  parameter logic [3:0]        REV_ID      = 4'h3,
  parameter logic [6:0]        SLV_ADDR    = 7'h69,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [3:0]        strap_i,
  output logic [N_RW*8-1:0] cfg_o,
  output logic [3:0]        freq_sel_o
);
  localparam int N_RD = N_RW + 2;

  logic scl_s, sda_s, start_p, stop_p, rise_p, fall_p;
  logic wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  smb_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_p), .stop_o(stop_p),
    .rise_o(rise_p), .fall_o(fall_p)
  );

  smb_link #(.SLV_ADDR(SLV_ADDR), .N_RD(N_RD)) u_link (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .start_i(start_p), .stop_i(stop_p),
    .rise_i(rise_p), .fall_i(fall_p), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_pull_o
  );

  clkcfg_regs #(.N_RW(N_RW), .RW_DEFAULTS(RW_DEFAULTS), .REV_ID(REV_ID)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .strap_i, .rd_data_o(rd_data), .cfg_o
  );

  // offset 0: bit 3 override, bits 7:4 code
  assign freq_sel_o = cfg_o[3] ? cfg_o[7:4] : strap_i;
endmodule

// File: rtl/clkcfg_smbus_chk.sv
module clkcfg_smbus_chk #(
  parameter int                N_RW        = 4,
  parameter logic [N_RW*8-1:0] RW_DEFAULTS = 32'h5AFF0B82
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              stop_p,
  input logic              sda_pull,
  input logic              wr_en,
  input logic [6:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic [N_RW*8-1:0] cfg,
  input logic [3:0]        strap,
  input logic [3:0]        fsel
);
  // R6
  reset_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (cfg == RW_DEFAULTS && !sda_pull));

  // R10
  pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull) |-> !$past(scl_s));

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_p |=> !sda_pull);

  // R7
  ro_write_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr >= 7'(N_RW)) |=> $stable(cfg));

  // R8
  strap_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg[3] |-> fsel == strap);

  for (genvar g = 0; g < N_RW; g++) begin : g_wr
    // R2
    reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && wr_addr == 7'(g)) |=> cfg[g*8 +: 8] == $past(wr_data));
  end
endmodule

bind clkcfg_smbus_slave clkcfg_smbus_chk #(.N_RW(N_RW), .RW_DEFAULTS(RW_DEFAULTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .stop_p(stop_p), .sda_pull(sda_pull_o),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg_o),
  .strap(strap_i), .fsel(freq_sel_o)
);

// File: tb/sim_clkcfg_smbus_slave.sv
module sim_clkcfg_smbus_slave;
  localparam int Q = 5;
  localparam int SLACK = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap = 4'h6;
  logic sda_pull;
  logic [31:0] cfg;
  logic [3:0] fsel;
  wire sda_bus = sda_m & ~sda_pull;

  clkcfg_smbus_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .strap_i(strap), .cfg_o(cfg), .freq_sel_o(fsel)
  );

  int n_chk = 0, n_fail = 0, mm = 0;
  bit mon_en = 0, done = 0;
  logic [7:0] mdl [4] = '{8'h82, 8'h0B, 8'hFF, 8'h5A};

  function automatic logic [3:0] mdl_fsel();
    return mdl[0][3] ? mdl[0][7:4] : strap;
  endfunction

  function automatic logic [7:0] exp_rd(int ofs);
    if (ofs < 4)  return mdl[ofs];
    if (ofs == 4) return {4'h0, strap};
    if (ofs == 5) return 8'h83;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // per-clock comparison against the model, tolerating the bus-to-register lag
  always @(negedge clk) if (mon_en) begin
    if (cfg === {mdl[3], mdl[2], mdl[1], mdl[0]} && fsel === mdl_fsel()) begin
      mm = 0; n_chk++;
    end else begin
      mm++;
      if (mm == SLACK) begin
        n_chk++; n_fail++;
        $display("FAIL R2/R8 monitor actual=%0h/%0h expected=%0h/%0h", cfg, fsel,
                 {mdl[3], mdl[2], mdl[1], mdl[0]}, mdl_fsel());
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1; wt(2*Q); scl_m = 0; wt(Q);
    end
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); ack = ~sda_bus; wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1; wt(Q); b[i] = sda_bus; wt(Q); scl_m = 0;
    end
    sda_m = nack; wt(Q); scl_m = 1; wt(2*Q); scl_m = 0; wt(Q); sda_m = 1;
  endtask

  task automatic byte_write(input logic [7:0] adr, input int ofs, input logic [7:0] d,
                            output logic [2:0] acks);
    bus_start();
    wr_byte(adr, acks[2]);
    if (acks[2]) begin
      wr_byte(8'h80 | 8'(ofs), acks[1]);
      wr_byte(d, acks[0]);
      if (ofs < 4) mdl[ofs] = d;
    end else acks[1:0] = 2'b00;
    bus_stop();
  endtask

  task automatic byte_read(input int ofs, output logic [7:0] d);
    logic a;
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h80 | 8'(ofs), a);
    bus_start(); wr_byte(8'hD3, a); rd_byte(1'b1, d);
    bus_stop();
  endtask

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic a, all_ack;
    wt(4); rst_ni = 1; wt(2);

    // R6 reset state
    chk("R6 defaults", cfg, 32'h5AFF0B82);
    chk("R6 sda released", {31'd0, sda_pull}, 0);
    chk("R8 strap source", {28'd0, fsel}, 4'h6);
    mon_en = 1;

    // R7 read-only registers
    byte_read(5, d); chk("R7 id byte", d, 8'h83);
    byte_read(4, d); chk("R7 strap byte", d, {4'h0, strap});

    // R2 / R1 byte write, R3 read back
    byte_write(8'hD2, 2, 8'h3C, acks); chk("R1 R2 acks", acks, 3'b111);
    byte_read(2, d); chk("R3 read back", d, 8'h3C);
    byte_read(1, d); chk("R3 default read", d, 8'h0B);

    // R1 foreign address ignored
    byte_write(8'hD4, 1, 8'hEE, acks); chk("R1 foreign nack", acks, 3'b000);
    wt(10); chk("R1 no change", cfg, {mdl[3], mdl[2], mdl[1], mdl[0]});

    // R7 writes to read-only offsets
    byte_write(8'hD2, 4, 8'hFF, acks); chk("R7 ro ack", acks, 3'b111);
    byte_write(8'hD2, 5, 8'h00, acks);
    byte_read(4, d); chk("R7 strap kept", d, 8'h06);
    byte_read(5, d); chk("R7 id kept", d, 8'h83);

    // R9 reserved offset
    byte_write(8'hD2, 9, 8'h77, acks); chk("R9 reserved ack", acks, 3'b111);
    byte_read(9, d); chk("R9 reserved read", d, 8'h00);
    chk("R9 no change", cfg, {mdl[3], mdl[2], mdl[1], mdl[0]});

    // R4 block write with surplus bytes
    bus_start(); wr_byte(8'hD2, all_ack); wr_byte(8'h00, a); all_ack &= a;
    wr_byte(8'd3, a); all_ack &= a;
    for (int k = 0; k < 4; k++) begin
      wr_byte(8'h11 * 8'(k + 1), a); all_ack &= a;
      if (k < 3) mdl[k] = 8'h11 * 8'(k + 1);
    end
    bus_stop();
    chk("R4 block acks", {31'd0, all_ack}, 1);
    wt(4); chk("R4 count limit", cfg, 32'h5A332211);

    // R4 early stop after one data byte
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'd4, a);
    wr_byte(8'hA5, a); mdl[0] = 8'hA5; bus_stop();
    wt(4); chk("R4 truncated", cfg, 32'h5A3322A5);

    // R8 override selects register copy
    byte_write(8'hD2, 0, 8'h98, acks);
    wt(4); chk("R8 override code", {28'd0, fsel}, 4'h9);
    strap = 4'hC; wt(4); chk("R8 strap ignored", {28'd0, fsel}, 4'h9);
    byte_write(8'hD2, 0, 8'h90, acks);
    wt(4); chk("R8 strap source again", {28'd0, fsel}, 4'hC);

    // R5 block read including past-end byte
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a);
    bus_start(); wr_byte(8'hD3, a);
    rd_byte(1'b0, d); chk("R5 count", d, 8'd6);
    for (int k = 0; k < 7; k++) begin
      rd_byte(k == 6, d); chk($sformatf("R5 block byte %0d", k), d, exp_rd(k));
    end
    bus_stop();
    wt(4); chk("R10 released after stop", {31'd0, sda_pull}, 0);

    wt(50);
    mon_en = 0;
    finish_up();
  end
endmodule